// File: doc/BRIEF.md
# Highway and Farm Road Crossing Signal Controller

This block sequences the lamps at a crossing where a busy highway meets a lightly used farm road. The highway stays green by default. A sensor reports cars waiting on the farm road. The farm road gets a green phase only when a car is waiting and the highway has already had a long green interval. The farm road then gives the right of way back as soon as its cars have gone or the long interval has run out. Each green phase is followed by a yellow phase that lasts one short interval.

An interval timer is built into the block. The controller restarts the timer on every change of phase, using a single-cycle restart pulse. The timer raises a short-interval flag and a long-interval flag after parameterised cycle counts. Both flags stay raised until the next restart. The current phase, the restart pulse and the two timer flags are all brought out as ports, together with the lamp codes for both roads.

Top module: `xroad_signal_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows the highway-green phase (code 00), with `short_up` and `long_up` low.
- R2: In highway-green, the controller moves to highway-yellow (code 01) only when `car_wait` and `long_up` are both high in the same cycle. Otherwise it stays in highway-green, even when `long_up` has been high for many cycles.
- R3: In highway-yellow, the controller stays while `short_up` is low. It moves to farm-green (code 11) in the cycle after `short_up` is high.
- R4: In farm-green, the controller stays while `car_wait` is high and `long_up` is low. It moves to farm-yellow (code 10) when `car_wait` is low or `long_up` is high.
- R5: In farm-yellow, the controller stays while `short_up` is low. It returns to highway-green in the cycle after `short_up` is high.
- R6: The lamp codes are green 00, yellow 01 and red 10. The codes are set by the phase alone: highway-green gives main 00 / side 10; highway-yellow gives 01 / 10; farm-green gives 10 / 00; farm-yellow gives 10 / 01.
- R7: `phase` shows the state with the encoding highway-green 00, highway-yellow 01, farm-green 11, farm-yellow 10.
- R8: `timer_restart` is high in exactly those cycles whose following cycle shows a different phase. It is low in all other cycles.
- R9: The timer counts clock cycles since the last restart or reset. `short_up` rises when the count reaches SHORT_CYCLES and `long_up` rises when it reaches LONG_CYCLES. Both flags hold until the next restart, and both read low in the cycle after a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| car_wait | input | 1 | A car is waiting on the farm road |
| lamp_main | output | 2 | Highway lamp code (00 green, 01 yellow, 10 red) |
| lamp_side | output | 2 | Farm road lamp code (00 green, 01 yellow, 10 red) |
| timer_restart | output | 1 | Single-cycle pulse in the cycle before a phase change |
| short_up | output | 1 | Short interval has elapsed since the last restart |
| long_up | output | 1 | Long interval has elapsed since the last restart |
| phase | output | 2 | Current phase code |

## Verification
The bench builds the block with SHORT_CYCLES=2 and LONG_CYCLES=4. With these values every yellow phase lasts three cycles and every long interval expires after five, so a 32-cycle vector table covers a full loop through all four phases twice. The table covers both exits from farm-green: one forced by the long timer and one taken early because the car left. It also covers a highway-green wait where the long flag is already up but no car is present. Directed tests then hold the long flag saturated for many cycles and apply reset in the middle of a yellow phase.

// File: rtl/xroad_pkg.sv
package xroad_pkg;

  typedef enum logic [1:0] {
    PH_MAIN_GO   = 2'b00,
    PH_MAIN_WARN = 2'b01,
    PH_SIDE_GO   = 2'b11,
    PH_SIDE_WARN = 2'b10
  } phase_t;

  typedef enum logic [1:0] {
    LAMP_GO   = 2'b00,
    LAMP_WARN = 2'b01,
    LAMP_STOP = 2'b10
  } lamp_t;

  typedef struct packed {
    lamp_t main_road;
    lamp_t side_road;
  } lamp_pair_t;

  // Lamp pair shown for a given phase.
  function automatic lamp_pair_t lamps_for(input phase_t ph);
    lamp_pair_t r;
    case (ph)
      PH_MAIN_GO:   begin r.main_road = LAMP_GO;   r.side_road = LAMP_STOP; end
      PH_MAIN_WARN: begin r.main_road = LAMP_WARN; r.side_road = LAMP_STOP; end
      PH_SIDE_GO:   begin r.main_road = LAMP_STOP; r.side_road = LAMP_GO;   end
      default:      begin r.main_road = LAMP_STOP; r.side_road = LAMP_WARN; end
    endcase
    return r;
  endfunction

  // Successor phase from the current phase and the three condition inputs.
  function automatic phase_t phase_after(input phase_t ph, input logic car,
                                         input logic short_done, input logic long_done);
    phase_t n;
    n = ph;
    case (ph)
      PH_MAIN_GO:   if (car && long_done)  n = PH_MAIN_WARN;
      PH_MAIN_WARN: if (short_done)        n = PH_SIDE_GO;
      PH_SIDE_GO:   if (!car || long_done) n = PH_SIDE_WARN;
      default:      if (short_done)        n = PH_MAIN_GO;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/xroad_interval_timer.sv
module xroad_interval_timer #(
  parameter int SHORT_CYCLES = 2,
  parameter int LONG_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = $clog2(LONG_CYCLES + 1);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYCLES);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYCLES);

  logic [CW-1:0] count_q;
  logic          at_limit;

  // The count saturates at the long limit so both flags hold until restart.
  assign at_limit = (count_q >= LONG_LIM);

  always_ff @(posedge clk) begin
    if (rst || restart) count_q <= '0;
    else if (!at_limit) count_q <= count_q + 1'b1;
  end

  assign short_done = (count_q >= SHORT_LIM);
  assign long_done  = at_limit;

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!short_done && !long_done));
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (short_done && !restart) |=> short_done);
  assert_long_after_short_R9: assert property (@(posedge clk) disable iff (rst)
    long_done |-> short_done);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!short_done && !long_done));

endmodule

// File: rtl/xroad_phase_logic.sv
module xroad_phase_logic
  import xroad_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   car,
  input  logic   short_done,
  input  logic   long_done,
  output phase_t phase_q,
  output logic   restart
);
  phase_t phase_d;

  always_comb phase_d = phase_after(phase_q, car, short_done, long_done);

  // Any change of phase restarts the interval timer.
  assign restart = (phase_d != phase_q);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_MAIN_GO;
    else     phase_q <= phase_d;
  end

  assert_main_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MAIN_GO && !(car && long_done)) |=> (phase_q == PH_MAIN_GO));
  assert_main_warn_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MAIN_WARN && !short_done) |=> (phase_q == PH_MAIN_WARN));
  assert_side_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SIDE_GO && (!car || long_done)) |=> (phase_q == PH_SIDE_WARN));
  assert_side_warn_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SIDE_WARN && short_done) |=> (phase_q == PH_MAIN_GO));
  assert_reset_phase_R1: assert property (@(posedge clk)
    rst |=> (phase_q == PH_MAIN_GO));

endmodule

// File: rtl/xroad_lamp_decode.sv
module xroad_lamp_decode
  import xroad_pkg::*;
(
  input  phase_t     phase,
  output logic [1:0] lamp_main,
  output logic [1:0] lamp_side
);
  lamp_pair_t pair;

  always_comb begin
    pair      = lamps_for(phase);
    lamp_main = pair.main_road;
    lamp_side = pair.side_road;
  end

  // At least one road always shows red.
  always_comb begin
    assert_one_road_red_R6: assert (lamp_main == LAMP_STOP || lamp_side == LAMP_STOP);
  end

endmodule

// File: rtl/xroad_signal_ctrl.sv
module xroad_signal_ctrl #(
  parameter int SHORT_CYCLES = 2,
  parameter int LONG_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_wait,
  output logic [1:0] lamp_main,
  output logic [1:0] lamp_side,
  output logic       timer_restart,
  output logic       short_up,
  output logic       long_up,
  output logic [1:0] phase
);
  import xroad_pkg::*;

  phase_t phase_w;
  logic   restart_w;
  logic   short_w;
  logic   long_w;

  xroad_interval_timer #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart_w),
    .short_done(short_w),
    .long_done (long_w)
  );

  xroad_phase_logic u_phase (
    .clk       (clk),
    .rst       (rst),
    .car       (car_wait),
    .short_done(short_w),
    .long_done (long_w),
    .phase_q   (phase_w),
    .restart   (restart_w)
  );

  xroad_lamp_decode u_lamps (
    .phase    (phase_w),
    .lamp_main(lamp_main),
    .lamp_side(lamp_side)
  );

  assign timer_restart = restart_w;
  assign short_up      = short_w;
  assign long_up       = long_w;
  assign phase         = phase_w;

  assert_pulse_changes_phase_R8: assert property (@(posedge clk) disable iff (rst)
    timer_restart |=> (phase != $past(phase)));
  assert_quiet_keeps_phase_R8: assert property (@(posedge clk) disable iff (rst)
    !timer_restart |=> $stable(phase));

endmodule

// File: tb/xroad_signal_ctrl_test.sv
module xroad_signal_ctrl_test;
  localparam int SHORT = 2;
  localparam int LONG  = 4;
  localparam int NVEC  = 32;

  // Fields: [5] car, [4:3] phase, [2] restart, [1] short flag, [0] long flag.
  localparam logic [5:0] VEC [NVEC] = '{
    6'b1_00_0_00, 6'b1_00_0_00, 6'b0_00_0_10, 6'b0_00_0_10,
    6'b0_00_0_11, 6'b0_00_0_11, 6'b1_00_1_11, 6'b1_01_0_00,
    6'b1_01_0_00, 6'b1_01_1_10, 6'b1_11_0_00, 6'b1_11_0_00,
    6'b1_11_0_10, 6'b1_11_0_10, 6'b1_11_1_11, 6'b0_10_0_00,
    6'b0_10_0_00, 6'b0_10_1_10, 6'b1_00_0_00, 6'b1_00_0_00,
    6'b1_00_0_10, 6'b1_00_0_10, 6'b1_00_1_11, 6'b1_01_0_00,
    6'b1_01_0_00, 6'b1_01_1_10, 6'b1_11_0_00, 6'b0_11_1_00,
    6'b1_10_0_00, 6'b1_10_0_00, 6'b1_10_1_10, 6'b1_00_0_00
  };

  logic       clk = 0;
  logic       rst = 1;
  logic       car_wait = 0;
  logic [1:0] lamp_main, lamp_side, phase;
  logic       timer_restart, short_up, long_up;
  int         checks = 0;
  int         failures = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  xroad_signal_ctrl #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) uut (
    .clk(clk), .rst(rst), .car_wait(car_wait),
    .lamp_main(lamp_main), .lamp_side(lamp_side),
    .timer_restart(timer_restart), .short_up(short_up), .long_up(long_up),
    .phase(phase)
  );

  function automatic logic [3:0] lamps_of(input logic [1:0] ph);
    // main, side: green 00, yellow 01, red 10
    if (ph == 2'b00) return 4'b00_10;
    if (ph == 2'b01) return 4'b01_10;
    if (ph == 2'b11) return 4'b10_00;
    return 4'b10_01;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [1:0] ph, input logic rs,
                           input logic sf, input logic lf);
    check("R7", {tag, " phase"}, int'(phase), int'(ph));
    check("R8", {tag, " restart"}, int'(timer_restart), int'(rs));
    check("R9", {tag, " short"}, int'(short_up), int'(sf));
    check("R9", {tag, " long"}, int'(long_up), int'(lf));
    check("R6", {tag, " lamps"}, int'({lamp_main, lamp_side}), int'(lamps_of(ph)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check_all("R1 reset", 2'b00, 1'b0, 1'b0, 1'b0);

    // Table walk: R2 R3 R4 R5 sequencing, R8 pulses, R9 flags.
    for (int i = 0; i < NVEC; i++) begin
      car_wait = VEC[i][5];
      #1;
      check_all($sformatf("vec%0d R2-5", i), VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0]);
      @(negedge clk);
    end

    // R2: long flag saturated, no car, highway green must hold.
    car_wait = 0;
    repeat (30) @(negedge clk);
    #1;
    check_all("R2 hold saturated", 2'b00, 1'b0, 1'b1, 1'b1);
    car_wait = 1;
    #1;
    check("R2", "exit pulse", int'(timer_restart), 1);
    @(negedge clk);
    #1;
    check_all("R3 entered yellow", 2'b01, 1'b0, 1'b0, 1'b0);

    // R1: reset in the middle of highway yellow.
    rst = 1;
    @(negedge clk);
    rst = 0;
    car_wait = 0;
    #1;
    check_all("R1 mid-yellow reset", 2'b00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    #1;
    check("R1", "phase after release", int'(phase), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule